// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the timing strobes for a serial transmitter and receiver from a single reference clock. The reference can optionally be divided by eight before it is used. The result then feeds a 16-bit clock divisor, which produces a one-cycle sample strobe for receiver oversampling. That strobe in turn feeds an 8-bit bit divisor, which produces the bit-rate strobe. The resulting bit rate is `f_ref / (P * CD * (BD + 1))`, where P is 8 when the prescaler is selected and 1 otherwise.

The divisor values and the prescale select arrive as steady register outputs from elsewhere in the chip. The block watches them itself. Any change to the select, either divisor or the enable restarts every counter from zero, so a reprogrammed rate never produces one truncated period. Clearing the enable holds both strobes low and parks the counters.

Top module: `serial_rate_gen`

## Requirements
- R1: While `rst_n` is low, `sample_tick` and `baud_tick` are both 0.
- R2: With `prescale_sel` = 0, `enable` = 1 and `clk_div` = CD ≥ 2, `sample_tick` is a one-cycle pulse every CD clock cycles. The first pulse comes CD cycles after the restart cycle. This holds up to CD = 65535.
- R3: With `prescale_sel` = 1, the sample period stretches to 8 × CD clock cycles. The first pulse comes 8 × CD cycles after the restart cycle.
- R4: For a legal `bit_div` = BD, `baud_tick` pulses in the same cycle as every (BD+1)-th `sample_tick`, counting from the restart. This holds at both ends of the legal range.
- R5: A `clk_div` of 0 or 1 keeps both `sample_tick` and `baud_tick` at 0.
- R6: `bit_div` is legal only from 4 through 254. Any other value keeps `baud_tick` at 0, while `sample_tick` continues normally.
- R7: While `enable` is 0, both strobes stay at 0. When `enable` returns to 1, the first strobes arrive only after a full period.
- R8: In the cycle after any change of `prescale_sel`, `clk_div` or `bit_div`, both strobes are 0 and all counts restart from zero. The next strobes therefore come a full period after the change, even when only `bit_div` changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 clears the counters |
| prescale_sel | input | 1 | 1 divides the reference by 8 before the clock divisor |
| clk_div | input | 16 | Clock divisor CD (active for 2..65535) |
| bit_div | input | 8 | Bit divisor BD, bit period = BD+1 samples (legal 4..254) |
| sample_tick | output | 1 | One-cycle sample strobe |
| baud_tick | output | 1 | One-cycle bit-rate strobe, coincident with a sample strobe |

## Verification
Each stage's count shows up directly in the strobe timing. A prescaler or clock-divisor count that is off by one moves every `sample_tick` by one or eight cycles, and this is visible at the first expected pulse. A stale bit-divisor count or a missed restart shifts the first `baud_tick` after a reconfiguration, so every run starts from a fresh setting and compares each cycle from the restart edge onward. Out-of-range divisors and the disabled state are checked cycle by cycle for complete silence on the affected strobe.

// File: rtl/srg_pkg.sv
package srg_pkg;

   // Prescaler source choice
   typedef enum logic {
      SRC_DIRECT = 1'b0,
      SRC_DIV    = 1'b1
   } src_sel_e;

   // Clock divisor must be at least two to produce strobes
   localparam int unsigned CD_ACTIVE_MIN = 2;

endpackage

// File: rtl/srg_prescale.sv
module srg_prescale #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic sel,
   output logic pre_en
);
   import srg_pkg::*;

   generate
      if (DIV > 1) begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] cnt;
         logic          wrap;

         assign wrap = (cnt == PW'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!go || src_sel_e'(sel) == SRC_DIRECT) begin
               cnt <= '0;
            end else begin
               cnt <= wrap ? '0 : cnt + PW'(1);
            end
         end

         assign pre_en = go & ((src_sel_e'(sel) == SRC_DIRECT) | wrap);

         // prescaled enables never sit back to back
         assert_pre_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && pre_en) |=> !pre_en);
      end else begin : g_pass
         assign pre_en = go;
      end
   endgenerate

endmodule

// File: rtl/srg_clk_div.sv
module srg_clk_div #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         pre_en,
   input  logic [W-1:0] divisor,
   output logic         strobe,
   output logic         tick_q
);
   import srg_pkg::*;

   logic [W-1:0] cnt;
   logic         active;

   assign active = (divisor >= W'(CD_ACTIVE_MIN));
   assign strobe = pre_en & active & (cnt == divisor - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= go & strobe;
         if (!go) begin
            cnt <= '0;
         end else if (pre_en && active) begin
            cnt <= strobe ? '0 : cnt + W'(1);
         end
      end
   end

   assert_sample_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);

   assert_no_sample_small_cd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor < W'(CD_ACTIVE_MIN)) |=> !tick_q);

endmodule

// File: rtl/srg_bit_div.sv
module srg_bit_div #(
   parameter int unsigned W   = 8,
   parameter int unsigned MIN = 4,
   parameter int unsigned MAX = 254
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         strobe,
   input  logic [W-1:0] divisor,
   output logic         tick_q
);
   logic [W-1:0] cnt;
   logic         legal;
   logic         last;

   assign legal = (divisor >= W'(MIN)) && (divisor <= W'(MAX));
   assign last  = (cnt == divisor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= go & strobe & legal & last;
         if (!go) begin
            cnt <= '0;
         end else if (strobe) begin
            cnt <= last ? '0 : cnt + W'(1);
         end
      end
   end

   assert_no_baud_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !legal |=> !tick_q);

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
   parameter int unsigned PRE_DIV = 8,
   parameter int unsigned CD_W    = 16,
   parameter int unsigned BD_W    = 8,
   parameter int unsigned BD_MIN  = 4,
   parameter int unsigned BD_MAX  = 254
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            prescale_sel,
   input  logic [CD_W-1:0] clk_div,
   input  logic [BD_W-1:0] bit_div,
   output logic            sample_tick,
   output logic            baud_tick
);
   localparam int unsigned CFG_W = 2 + CD_W + BD_W;

   generate
      if (CD_W < 2)              begin : g_bad_cd  $error("clock divisor too narrow"); end
      if (BD_MIN > BD_MAX)       begin : g_bad_rng $error("bit divisor range empty"); end
      if (BD_MAX >= (1 << BD_W)) begin : g_bad_bdw $error("bit divisor max exceeds width"); end
      if (PRE_DIV < 1)           begin : g_bad_pre $error("prescale must be positive"); end
   endgenerate

   logic [CFG_W-1:0] cfg_now, cfg_prev;
   logic             restart, go, pre_en, cd_strobe;

   assign cfg_now = {enable, prescale_sel, clk_div, bit_div};
   assign restart = (cfg_now != cfg_prev);
   assign go      = enable & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_prev <= '0;
      else        cfg_prev <= cfg_now;
   end

   srg_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .go(go), .sel(prescale_sel), .pre_en(pre_en)
   );

   srg_clk_div #(.W(CD_W)) u_cd (
      .clk(clk), .rst_n(rst_n), .go(go), .pre_en(pre_en), .divisor(clk_div),
      .strobe(cd_strobe), .tick_q(sample_tick)
   );

   srg_bit_div #(.W(BD_W), .MIN(BD_MIN), .MAX(BD_MAX)) u_bd (
      .clk(clk), .rst_n(rst_n), .go(go), .strobe(cd_strobe), .divisor(bit_div),
      .tick_q(baud_tick)
   );

   assert_baud_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |-> sample_tick);

   assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!sample_tick && !baud_tick));

   assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sample_tick && !baud_tick));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (!sample_tick && !baud_tick));

endmodule

// File: tb/serial_rate_gen_test.sv
module serial_rate_gen_test;

   typedef struct {
      logic  s;
      logic  b;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        prescale_sel = 1'b0;
   logic [15:0] clk_div = '0;
   logic [7:0]  bit_div = '0;
   logic        sample_tick, baud_tick;

   int   vectors = 0;
   int   errors  = 0;
   exp_t q[$];

   always #5 clk = ~clk;

   serial_rate_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .prescale_sel(prescale_sel),
      .clk_div(clk_div), .bit_div(bit_div),
      .sample_tick(sample_tick), .baud_tick(baud_tick)
   );

   task automatic compare(input logic es, input logic eb, input string tag);
      vectors++;
      if (sample_tick !== es || baud_tick !== eb) begin
         errors++;
         $display("FAIL %s at %0t: sample/baud actual %b%b expected %b%b",
                  tag, $time, sample_tick, baud_tick, es, eb);
      end
   endtask

   // Expected strobes j edges after the restart edge (j = 0 is the restart)
   function automatic exp_t model(input logic en, input logic sel, input int cd,
                                  input int bd, input int j, input string tag);
      exp_t e;
      int   pulses;
      e.s = 1'b0; e.b = 1'b0; e.tag = tag;
      if (!en || j == 0) return e;
      if (sel && (j % 8) != 0) return e;
      pulses = sel ? j / 8 : j;
      if (cd < 2) return e;
      if ((pulses % cd) != 0) return e;
      e.s = 1'b1;
      e.b = (bd >= 4 && bd <= 254) && (((pulses / cd) % (bd + 1)) == 0);
      return e;
   endfunction

   // Driver: apply a setting and queue the expected strobes
   task automatic run(input logic en, input logic sel, input int cd, input int bd,
                      input int n, input string tag);
      @(negedge clk);
      enable       = en;
      prescale_sel = sel;
      clk_div      = 16'(cd);
      bit_div      = 8'(bd);
      for (int j = 0; j <= n; j++) q.push_back(model(en, sel, cd, bd, j, tag));
      while (q.size() != 0) @(negedge clk);
   endtask

   // Monitor: compare after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e.s, e.b, e.tag);
         end
      end
   end

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      // R1: quiet during reset, even with a live setting applied
      repeat (2) @(negedge clk);
      compare(1'b0, 1'b0, "R1");
      enable = 1'b1; clk_div = 16'd2; bit_div = 8'd4;
      repeat (4) @(negedge clk);
      compare(1'b0, 1'b0, "R1");
      enable = 1'b0; clk_div = '0; bit_div = '0;
      @(negedge clk);
      rst_n = 1'b1;

      run(1, 0, 5, 4, 80, "R2/R4");          // sample every 5, bit every 25
      run(1, 1, 3, 4, 400, "R3/R4");         // sample every 24, bit every 120
      run(1, 0, 0, 4, 40, "R5 cd0");
      run(1, 0, 1, 4, 40, "R5 cd1");
      run(1, 0, 3, 2, 80, "R6 bd2");
      run(1, 0, 3, 255, 80, "R6 bd255");
      run(1, 0, 3, 3, 80, "R6 bd3");
      run(1, 0, 2, 254, 600, "R4 bdmax");    // bit strobe at 510
      run(1, 0, 2, 4, 40, "R4 bdmin");
      run(0, 0, 5, 4, 50, "R7 off");
      run(1, 0, 5, 4, 60, "R7 on");
      run(1, 0, 6, 4, 10, "R8 pre");
      run(1, 0, 6, 5, 90, "R8 bd only");     // sample counter restarts too
      run(1, 1, 6, 5, 120, "R8 sel only");
      run(1, 1, 7, 5, 3, "R8 cd only");
      run(1, 0, 65535, 4, 65540, "R2 cdmax");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule